// File: doc/BRIEF.md
# Opcode-Addressed Serial EEPROM Command Front End

This block sits between the bit-level layer of a single-wire serial EEPROM and its storage. It sees each received byte together with start and stop markers. It answers each byte with an acknowledge or with silence, and it returns read bytes when the host asks for them. The first byte after a start is a device address byte. Its upper nibble is an opcode that picks one of two regions: a 128-byte main array, or a 32-byte security region whose lower 16 bytes hold a fixed serial number. The byte also carries a 3-bit slave address and a direction bit.

A write carries a memory address byte followed by data bytes. The data bytes collect in an 8-byte page buffer, and a stop commits them. The commit starts a busy period of programmable length, and during that period the block acknowledges nothing. A read sends a device byte with the direction bit set, after a dummy write has set the pointer. Each read request then returns the byte at the pointer and advances it.

Top module: `eeprom_cmd_ctrl`

## Requirements
- R1: Every received byte gets `resp_valid_o` one cycle later. A device address byte (the first byte after a start) is acknowledged (`resp_ack_o`=1) exactly when bits 7:4 equal 0xA (main array) or 0xB (security region) and bits 3:1 equal `SLAVE_ADDR`. Bit 0 = 1 selects read and bit 0 = 0 selects write.
- R2: After a device address byte that is not acknowledged, the block stays silent: every further byte gets `resp_ack_o`=0 until the next start.
- R3: In a write, the byte after the device address byte is the memory address and is acknowledged. Bits 6:0 set the pointer and bit 7 has no effect. In the security region only bits 4:0 are kept.
- R4: Data bytes of a write are acknowledged and buffered. Byte k lands at the page base plus ((start column + k) mod 8), so it wraps inside the 8-byte page. A ninth or later byte replaces the earlier entry in the same slot.
- R5: A stop after at least one acknowledged data byte writes the buffered bytes and raises `busy_o` for exactly `BUSY_CYCLES` cycles, starting the cycle after the stop. A stop with no data byte written raises no busy period.
- R6: While `busy_o` is high, every byte, including device address bytes, gets `resp_ack_o`=0 and changes no stored data.
- R7: In a read, `rd_req_i` gives `rd_valid_o` one cycle later with the byte at the pointer. The pointer then advances and wraps at the end of the region (128 bytes for main, 32 bytes for security).
- R8: Security bytes 0 to 15 read as (i*37+5) mod 256. Writes to them are acknowledged but discarded. Security bytes 16 to 31 are writable.
- R9: A host NACK (`host_nack_i`) during a read ends it, and later `rd_req_i` give no `rd_valid_o` until the next start.
- R10: After reset, all main bytes and security bytes 16 to 31 read 0xFF, and `busy_o`, `resp_valid_o` and `rd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start condition marker, one cycle |
| stop_i | input | 1 | Stop condition marker, one cycle |
| byte_valid_i | input | 1 | A byte from the host is present on `byte_i` |
| byte_i | input | 8 | Byte received from the host |
| resp_valid_o | output | 1 | Response to the byte of the previous cycle |
| resp_ack_o | output | 1 | 1 = acknowledge, 0 = no response |
| rd_req_i | input | 1 | Host requests the next read byte |
| host_nack_i | input | 1 | Host did not acknowledge the last read byte |
| rd_valid_o | output | 1 | `rd_data_o` holds a read byte |
| rd_data_o | output | 8 | Read byte |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
The embedded assertions check the following on every cycle: the one-cycle response and read-data latency, silence whenever busy, that busy starts only after a stop and that its counter stays in range, the absence of read data after a host NACK, and that every buffered write slot is marked. Only the bench scenarios can show the rest. These are the full decode table of the device byte, the page-wrap and overwrite placement of data bytes, the exact busy length, the discarding of serial-number writes, and the wrap of sequential reads at each region's end. The bench shows these by reading the stored contents back through the read path.

// File: rtl/eeprom_cmd_pkg.sv
// Package: shared state type, opcode values and the serial-number generator.
// Assumes: consumers import it before declaring ports or types that use it.
package eeprom_cmd_pkg;

    localparam logic [3:0] OP_MAIN = 4'hA;
    localparam logic [3:0] OP_SEC  = 4'hB;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DEV,
        S_MADR,
        S_WDAT,
        S_RDAT,
        S_REND,
        S_BUSY
    } ctrl_state_e;

    // Fixed serial-number byte at read-only security index i.
    function automatic logic [7:0] serial_byte(input int i);
        return 8'(i * 37 + 5);
    endfunction

endpackage

// File: rtl/eeprom_dev_decode.sv
// Device address byte decoder: splits out the opcode, compares the slave address.
// Assumes: the caller applies the result only to the first byte after a start.
module eeprom_dev_decode #(
    parameter logic [2:0] SLAVE_ADDR = 3'b010
) (
    input  logic [7:0] dev_byte_i,
    output logic       hit_o,
    output logic       sec_o,
    output logic       rd_o
);
    import eeprom_cmd_pkg::*;

    logic [3:0] opcode;

    // Combine the opcode check and the slave address match.
    always_comb begin
        opcode = dev_byte_i[7:4];
        sec_o  = (opcode == OP_SEC);
        rd_o   = dev_byte_i[0];
        hit_o  = ((opcode == OP_MAIN) || (opcode == OP_SEC)) &&
                 (dev_byte_i[3:1] == SLAVE_ADDR);
    end

endmodule

// File: rtl/eeprom_page_buf.sv
// Page write buffer: one byte slot per column of a page, with a valid mask.
// Assumes: clear_i and wr_i are never high in the same cycle.
module eeprom_page_buf #(
    parameter int PAGE_BYTES = 8,
    localparam int COL_W = $clog2(PAGE_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear_i,
    input  logic                        wr_i,
    input  logic [COL_W-1:0]            col_i,
    input  logic [7:0]                  data_i,
    output logic [PAGE_BYTES-1:0][7:0]  data_o,
    output logic [PAGE_BYTES-1:0]       mask_o
);

    // Store a byte at its column; a later byte in the same column replaces it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            mask_o <= '0;
            data_o <= '0;
        end else if (wr_i) begin
            mask_o[col_i] <= 1'b1;
            data_o[col_i] <= data_i;
        end
    end

    // R4
    slot_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clear_i) |=> (mask_o[$past(col_i)] && data_o[$past(col_i)] == $past(data_i)));

endmodule

// File: rtl/eeprom_store.sv
// Storage: main array, writable upper half of the security region, and a
// computed read-only serial number in its lower half. Writes come one page at a time.
// Assumes: page_i addresses a page inside the region selected by commit_sec_i.
module eeprom_store #(
    parameter int MAIN_BYTES = 128,
    parameter int SEC_BYTES  = 32,
    parameter int PAGE_BYTES = 8,
    localparam int ADDR_W = $clog2(MAIN_BYTES),
    localparam int SEC_W  = $clog2(SEC_BYTES),
    localparam int COL_W  = $clog2(PAGE_BYTES),
    localparam int PAGE_W = ADDR_W - COL_W,
    localparam int LOCK   = SEC_BYTES / 2,
    localparam int LOCK_W = $clog2(LOCK)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sec_i,
    input  logic [ADDR_W-1:0]           addr_i,
    output logic [7:0]                  rdata_o,
    input  logic                        commit_i,
    input  logic                        commit_sec_i,
    input  logic [PAGE_W-1:0]           page_i,
    input  logic [PAGE_BYTES-1:0][7:0]  wdata_i,
    input  logic [PAGE_BYTES-1:0]       wmask_i
);
    import eeprom_cmd_pkg::*;

    logic [7:0] main_q [MAIN_BYTES];
    logic [7:0] user_q [LOCK];
    int         sidx;

    // Erase to 0xFF on reset; on commit write every valid slot of the page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAIN_BYTES; i++) main_q[i] <= 8'hFF;
            for (int i = 0; i < LOCK; i++)       user_q[i] <= 8'hFF;
        end else if (commit_i) begin
            for (int s = 0; s < PAGE_BYTES; s++) begin
                if (wmask_i[s]) begin
                    if (!commit_sec_i) begin
                        main_q[ADDR_W'(int'(page_i) * PAGE_BYTES + s)] <= wdata_i[s];
                    end else if ((int'(page_i) * PAGE_BYTES + s) >= LOCK &&
                                 (int'(page_i) * PAGE_BYTES + s) < SEC_BYTES) begin
                        user_q[LOCK_W'(int'(page_i) * PAGE_BYTES + s - LOCK)] <= wdata_i[s];
                    end
                end
            end
        end
    end

    // Read port: the serial number is computed, the other bytes come from registers.
    always_comb begin
        sidx = int'(addr_i[SEC_W-1:0]);
        if (!sec_i)
            rdata_o = main_q[addr_i];
        else if (sidx < LOCK)
            rdata_o = serial_byte(sidx);
        else
            rdata_o = user_q[LOCK_W'(sidx - LOCK)];
    end

endmodule

// File: rtl/eeprom_cmd_ctrl.sv
// Command front end: answers device/address/data bytes, runs reads and page
// writes, and holds off all traffic during the programmable busy period.
// Assumes: start_i, stop_i and byte_valid_i are one-cycle markers that never coincide.
module eeprom_cmd_ctrl #(
    parameter int         MAIN_BYTES  = 128,
    parameter int         SEC_BYTES   = 32,
    parameter int         PAGE_BYTES  = 8,
    parameter int         BUSY_CYCLES = 16,
    parameter logic [2:0] SLAVE_ADDR  = 3'b010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       byte_valid_i,
    input  logic [7:0] byte_i,
    output logic       resp_valid_o,
    output logic       resp_ack_o,
    input  logic       rd_req_i,
    input  logic       host_nack_i,
    output logic       rd_valid_o,
    output logic [7:0] rd_data_o,
    output logic       busy_o
);
    import eeprom_cmd_pkg::*;

    localparam int ADDR_W = $clog2(MAIN_BYTES);
    localparam int SEC_W  = $clog2(SEC_BYTES);
    localparam int COL_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - COL_W;
    localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);

    ctrl_state_e                 st_q;
    logic [ADDR_W-1:0]           ptr_q;
    logic                        sec_q;
    logic [CNT_W-1:0]            cnt_q;
    logic                        dev_hit, dev_sec, dev_rd;
    logic                        live, ack_now, buf_clr, buf_wr, commit, rd_fire;
    logic [PAGE_BYTES-1:0][7:0]  buf_data;
    logic [PAGE_BYTES-1:0]       buf_mask;
    logic [7:0]                  mem_rdata;
    logic [ADDR_W-1:0]           ptr_cap, ptr_col_inc, ptr_rd_inc;

    eeprom_dev_decode #(.SLAVE_ADDR(SLAVE_ADDR)) dec_i (
        .dev_byte_i (byte_i),
        .hit_o      (dev_hit),
        .sec_o      (dev_sec),
        .rd_o       (dev_rd)
    );

    eeprom_page_buf #(.PAGE_BYTES(PAGE_BYTES)) pbuf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (buf_clr),
        .wr_i    (buf_wr),
        .col_i   (ptr_q[COL_W-1:0]),
        .data_i  (byte_i),
        .data_o  (buf_data),
        .mask_o  (buf_mask)
    );

    eeprom_store #(
        .MAIN_BYTES (MAIN_BYTES),
        .SEC_BYTES  (SEC_BYTES),
        .PAGE_BYTES (PAGE_BYTES)
    ) store_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sec_i        (sec_q),
        .addr_i       (ptr_q),
        .rdata_o      (mem_rdata),
        .commit_i     (commit),
        .commit_sec_i (sec_q),
        .page_i       (ptr_q[ADDR_W-1:COL_W]),
        .wdata_i      (buf_data),
        .wmask_i      (buf_mask)
    );

    // Decide acknowledge, buffer actions, commit and read firing for this cycle.
    always_comb begin
        live        = (st_q != S_BUSY) && !start_i && !stop_i;
        ack_now     = live && byte_valid_i &&
                      ((st_q == S_DEV && dev_hit) || st_q == S_MADR || st_q == S_WDAT);
        buf_clr     = (st_q != S_BUSY) && (start_i || (live && byte_valid_i && st_q == S_MADR));
        buf_wr      = live && byte_valid_i && st_q == S_WDAT;
        commit      = (st_q == S_WDAT) && !start_i && stop_i && (|buf_mask);
        rd_fire     = live && rd_req_i && st_q == S_RDAT;
        ptr_cap     = sec_q ? ADDR_W'(byte_i[SEC_W-1:0]) : byte_i[ADDR_W-1:0];
        ptr_col_inc = {ptr_q[ADDR_W-1:COL_W], ptr_q[COL_W-1:0] + COL_W'(1)};
        ptr_rd_inc  = sec_q ? ADDR_W'(ptr_q[SEC_W-1:0] + SEC_W'(1)) : ptr_q + ADDR_W'(1);
    end

    // Command state machine, pointer and busy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            ptr_q <= '0;
            sec_q <= 1'b0;
            cnt_q <= '0;
        end else if (st_q == S_BUSY) begin
            if (cnt_q == CNT_W'(BUSY_CYCLES - 1)) begin
                st_q  <= S_IDLE;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end else if (start_i) begin
            st_q <= S_DEV;
        end else if (stop_i) begin
            st_q  <= commit ? S_BUSY : S_IDLE;
            cnt_q <= '0;
        end else if (byte_valid_i) begin
            case (st_q)
                S_DEV: begin
                    if (dev_hit) begin
                        sec_q <= dev_sec;
                        st_q  <= dev_rd ? S_RDAT : S_MADR;
                    end else begin
                        st_q  <= S_IDLE;
                    end
                end
                S_MADR: begin
                    ptr_q <= ptr_cap;
                    st_q  <= S_WDAT;
                end
                S_WDAT:  ptr_q <= ptr_col_inc;
                default: st_q  <= st_q;
            endcase
        end else if (rd_fire) begin
            ptr_q <= ptr_rd_inc;
        end else if (st_q == S_RDAT && host_nack_i) begin
            st_q <= S_REND;
        end
    end

    // Registered byte response and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_o <= 1'b0;
            resp_ack_o   <= 1'b0;
            rd_valid_o   <= 1'b0;
            rd_data_o    <= '0;
        end else begin
            resp_valid_o <= byte_valid_i;
            resp_ack_o   <= ack_now;
            rd_valid_o   <= rd_fire;
            if (rd_fire) rd_data_o <= mem_rdata;
        end
    end

    assign busy_o = (st_q == S_BUSY);

    // R1
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_i |=> resp_valid_o);

    // R6
    busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && resp_valid_o) |-> !resp_ack_o);

    // R5
    busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i));

    // R5
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cnt_q < CNT_W'(BUSY_CYCLES)));

    // R7
    rd_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(rd_req_i));

    // R9
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_REND) |=> !rd_valid_o);

endmodule

// File: tb/eeprom_cmd_ctrl_tb.sv
module eeprom_cmd_ctrl_tb_top;

    localparam int         BUSY = 16;
    localparam logic [2:0] SLV  = 3'b010;
    localparam logic [7:0] DEV_MW = {4'hA, SLV, 1'b0};
    localparam logic [7:0] DEV_MR = {4'hA, SLV, 1'b1};
    localparam logic [7:0] DEV_SW = {4'hB, SLV, 1'b0};
    localparam logic [7:0] DEV_SR = {4'hB, SLV, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, stop_i = 1'b0, byte_valid_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic rd_req_i = 1'b0, host_nack_i = 1'b0;
    logic resp_valid_o, resp_ack_o, rd_valid_o, busy_o;
    logic [7:0] rd_data_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] m_main [128];
    logic [7:0] m_user [16];

    always #10 clk = ~clk;

    eeprom_cmd_ctrl #(.BUSY_CYCLES(BUSY), .SLAVE_ADDR(SLV)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i),
        .resp_valid_o(resp_valid_o), .resp_ack_o(resp_ack_o),
        .rd_req_i(rd_req_i), .host_nack_i(host_nack_i),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_sec(input int a);
        return (a < 16) ? 8'(a * 37 + 5) : m_user[a - 16];
    endfunction

    task automatic pulse_start();
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
        byte_valid_i = 1'b1; byte_i = b;
        @(negedge clk);
        byte_valid_i = 1'b0;
        chk(resp_valid_o && (resp_ack_o == exp_ack), req, {resp_valid_o, resp_ack_o}, {1'b1, exp_ack});
    endtask

    task automatic read_one(input logic [7:0] exp, input string req);
        rd_req_i = 1'b1;
        @(negedge clk);
        rd_req_i = 1'b0;
        chk(rd_valid_o && rd_data_o == exp, req, {rd_valid_o, rd_data_o}, {1'b1, exp});
    endtask

    task automatic wait_busy(input int exp_n);
        int n = 0;
        while (busy_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp_n, "R5 busy length", n, exp_n);
    endtask

    task automatic write_seq(input bit sec, input int a, input int n, input int seed);
        int eff = sec ? (a & 31) : (a & 127);
        pulse_start();
        send(sec ? DEV_SW : DEV_MW, 1'b1, "R1");
        send(8'(a), 1'b1, "R3");
        for (int k = 0; k < n; k++) begin
            logic [7:0] d = 8'(seed + k * 13);
            int ad = (eff & ~7) | ((eff + k) & 7);
            send(d, 1'b1, "R4");
            if (!sec) m_main[ad] = d;
            else if (ad >= 16) m_user[ad - 16] = d;
        end
        pulse_stop();
        wait_busy(BUSY);
    endtask

    task automatic read_seq(input bit sec, input int a, input int n, input string req);
        int eff = sec ? (a & 31) : (a & 127);
        pulse_start();
        send(sec ? DEV_SW : DEV_MW, 1'b1, "R1");
        send(8'(a), 1'b1, "R3");
        pulse_start();
        send(sec ? DEV_SR : DEV_MR, 1'b1, "R1");
        for (int k = 0; k < n; k++) begin
            read_one(sec ? exp_sec(eff) : m_main[eff], req);
            eff = sec ? ((eff + 1) % 32) : ((eff + 1) % 128);
        end
        host_nack_i = 1'b1; @(negedge clk); host_nack_i = 1'b0;
        pulse_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) m_main[i] = 8'hFF;
        for (int i = 0; i < 16; i++)  m_user[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state of outputs and contents
        chk(!busy_o && !resp_valid_o && !rd_valid_o, "R10 outputs", {busy_o, resp_valid_o, rd_valid_o}, 0);
        read_seq(1'b0, 0, 128, "R10 main erased");
        read_seq(1'b1, 0, 32, "R8 serial and R10 user erased");

        // R1/R2 full sweep of the device address byte
        for (int b = 0; b < 256; b++) begin
            logic [7:0] bv = 8'(b);
            bit hit = ((bv[7:4] == 4'hA) || (bv[7:4] == 4'hB)) && (bv[3:1] == SLV);
            pulse_start();
            send(bv, hit, "R1 decode");
            if (!hit) send(8'h00, 1'b0, "R2 silent");
            pulse_stop();
            chk(!busy_o, "R5 no data no busy", busy_o, 0);
        end

        // R4/R5 fill the whole main array page by page, then R7 read with wrap
        for (int p = 0; p < 16; p++) write_seq(1'b0, p * 8, 8, p * 29 + 1);
        read_seq(1'b0, 0, 130, "R7 main sequential wrap");

        // R4 wrap inside page 3 and overwrite past 8 bytes in page 8
        write_seq(1'b0, 8'h1E, 4, 8'h31);
        read_seq(1'b0, 8'h18, 8, "R4 page wrap");
        write_seq(1'b0, 8'h40, 10, 8'h52);
        read_seq(1'b0, 8'h40, 8, "R4 overwrite");

        // R3 bit 7 of the memory address has no effect
        write_seq(1'b0, 8'h85, 1, 8'h77);
        read_seq(1'b0, 8'h05, 1, "R3 bit7 ignored");

        // R8 serial region discards writes, user pages keep them; R7 wrap at 32
        write_seq(1'b1, 8'h02, 3, 8'h10);
        write_seq(1'b1, 8'h1C, 6, 8'h90);
        read_seq(1'b1, 30, 34, "R8 R7 security");

        // R5 stop straight after the memory address byte
        pulse_start();
        send(DEV_MW, 1'b1, "R1");
        send(8'h10, 1'b1, "R3");
        pulse_stop();
        chk(!busy_o, "R5 address only", busy_o, 0);

        // R6 no answer during the busy period
        pulse_start();
        send(DEV_MW, 1'b1, "R1");
        send(8'h20, 1'b1, "R3");
        send(8'h5A, 1'b1, "R4");
        m_main[8'h20] = 8'h5A;
        pulse_stop();
        chk(busy_o, "R6 busy raised", busy_o, 1);
        pulse_start();
        send(DEV_MW, 1'b0, "R6 busy device byte");
        send(8'h21, 1'b0, "R6 busy data byte");
        wait_busy(BUSY - 3);
        read_seq(1'b0, 8'h1E, 6, "R6 contents intact");

        // R9 host NACK ends the read
        pulse_start();
        send(DEV_MR, 1'b1, "R1");
        rd_req_i = 1'b1; @(negedge clk); rd_req_i = 1'b0;
        chk(rd_valid_o, "R7 read before nack", rd_valid_o, 1);
        host_nack_i = 1'b1; @(negedge clk); host_nack_i = 1'b0;
        rd_req_i = 1'b1; @(negedge clk); rd_req_i = 1'b0;
        chk(!rd_valid_o, "R9 read after nack", rd_valid_o, 0);
        pulse_stop();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule